// File: doc/BRIEF.md
# BCD calendar clock with alarm

This block keeps the time of day and the calendar for a chip that must wake a host at set times. A 15-bit divider counts a 32.768 kHz clock-enable input and produces one advance per second. Each advance moves seconds, minutes, hours, day of week, date, month and a two-digit year forward, all held in BCD. The hours field runs either in 24-hour form or in 12-hour form with a PM flag.

A time-of-day alarm compares seconds, minutes, hours and day of week against four alarm registers. Each alarm register has a mask bit, so the alarm can repeat every second, every minute, every hour, every day or every week. A match sets an interrupt flag that the host clears by reading the status register. The interrupt output follows that flag only while the alarm enable bit is set. The host reaches every register through a simple single-cycle register port. The read data is combinational on the address.

Top module: `rtc_cal_core`

## Requirements
- R1: Seconds (address 0h) and minutes (address 1h) count BCD 00 to 59. Seconds 59 becomes 00 and carries into minutes. Minutes 59 becomes 00 and carries into hours.
- R2: With hours bit 6 = 0 (24-hour), hours count BCD 00 to 23. The step from 23 goes to 00 and carries into both the day of week and the date. Day of week (address 3h) counts 1 to 7 and then wraps to 1.
- R3: With hours bit 6 = 1 (12-hour), bit 5 is PM (1 = PM) and bits 4:0 hold BCD 01 to 12. The sequence is 12 AM, 1 to 11 AM, 12 PM, 1 to 11 PM. Only the step from 11 PM to 12 AM carries into the day. For example, 0x51 becomes 0x72, 0x52 becomes 0x41, and 0x71 becomes 0x52 with a carry.
- R4: Date (address 4h) wraps to 01 after the last day of the month. April, June, September and November have 30 days. February has 29 days when the year (address 6h) is divisible by 4, including year 00, and 28 days otherwise. All other months have 31 days. Month (address 5h) 12 wraps to 01 and increments the year. Year 99 wraps to 00.
- R5: One second passes every 2^DIV_W strobes of tick32k_i (DIV_W = 15 by default). An accepted write to the seconds register restarts this count.
- R6: Control register (address Bh) bit 7 = 1 halts the clock. While it is set, no time register advances.
- R7: While control bit 6 = 1, every register write is ignored. The one exception is a write to the control register: it changes bit 6 only, so protection can be cleared.
- R8: Unused bits read 0 whatever is written. Time registers keep these bits: seconds, minutes and hours bits 6:0; day bits 2:0; date bits 5:0; month bits 4:0; year all bits. Alarm registers keep all bits, except the day alarm, which keeps bits 7 and 2:0. The control register keeps bits 7:4 and 0. Addresses Dh to Fh read 0.
- R9: Alarm registers sit at addresses 7h (seconds), 8h (minutes), 9h (hours) and Ah (day). Bit 7 of each is a mask. A masked field always matches. An unmasked field matches when its low bits equal the time field; for hours this covers bits 6:0, and for day it covers bits 2:0. Masks 1111, 0111, 0011, 0001 and 0000 (seconds, minutes, hours, day) give alarms every second, on a seconds match, on a minutes and seconds match, on an hours, minutes and seconds match, and on a full day-and-time match.
- R10: The interrupt flag is bit 0 of the status register (address Ch). It sets on the edge after a one-second advance that produces a match. It clears on the edge that ends a read of the status register with reg_re_i = 1. A set on the same edge wins over the clear.
- R11: irq_o is high while the flag is set and control bit 0 (alarm enable) is 1. With control bit 0 = 0, the flag still sets but irq_o stays low.
- R12: After reset the clock reads 00:00:00 in 24-hour mode, day 1, date 01, month 01, year 00. The alarm, control and status registers read 00, and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick32k_i | input | 1 | One-cycle strobe at 32.768 kHz |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (clears the flag on a status read) |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational on the address |
| irq_o | output | 1 | Active-high alarm interrupt |

## Verification
A register write takes effect on the clock edge that ends the write cycle. Read data is combinational, so a read in the following cycle already shows the new value. After a seconds write, the advance lands on the 2^DIV_W-th strobe edge, and the flag and irq_o follow one edge later. The bench runs with a short divider and always writes seconds last, which puts the divider at zero. It then applies exactly 2^DIV_W strobes, waits two further edges and samples at the falling edge. A flag clear is checked in the cycle after the status read, because the clear only happens on the edge that ends the read.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_SEC   = 4'h0;
  localparam logic [ADDR_W-1:0] A_MIN   = 4'h1;
  localparam logic [ADDR_W-1:0] A_HOUR  = 4'h2;
  localparam logic [ADDR_W-1:0] A_DAY   = 4'h3;
  localparam logic [ADDR_W-1:0] A_DATE  = 4'h4;
  localparam logic [ADDR_W-1:0] A_MON   = 4'h5;
  localparam logic [ADDR_W-1:0] A_YEAR  = 4'h6;
  localparam logic [ADDR_W-1:0] A_ASEC  = 4'h7;
  localparam logic [ADDR_W-1:0] A_AMIN  = 4'h8;
  localparam logic [ADDR_W-1:0] A_AHOUR = 4'h9;
  localparam logic [ADDR_W-1:0] A_ADAY  = 4'hA;
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'hB;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'hC;

  localparam logic [7:0] CTRL_MASK = 8'hF1;
  localparam int unsigned CTRL_HALT = 7;
  localparam int unsigned CTRL_WP   = 6;
  localparam int unsigned CTRL_AIE  = 0;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // 10*t + u is divisible by 4 exactly when 2*t + u is
  function automatic logic is_leap(input logic [7:0] y);
    logic [4:0] s;
    s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
    return s[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV_W = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic clr_i,
  output logic pulse_o
);
  localparam logic [DIV_W-1:0] CNT_MAX = {DIV_W{1'b1}};

  logic [DIV_W-1:0] cnt_q;

  assign pulse_o = tick_i && run_i && !clr_i && (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (tick_i && run_i) cnt_q <= cnt_q + 1'b1;
  end

  // R5: a second boundary leaves the divider at zero
  a_r5_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> (cnt_q == '0));

  // R6: a halted divider holds its count
  a_r6_halt_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic [7:0]        sec_o,
  output logic [7:0]        min_o,
  output logic [7:0]        hour_o,
  output logic [7:0]        day_o,
  output logic [7:0]        date_o,
  output logic [7:0]        mon_o,
  output logic [7:0]        year_o,
  output logic              adv_done_o
);
  logic time_wr, adv;
  logic [7:0] sec_n, min_n, hour_n, day_n, date_n, mon_n, year_n;
  logic c_min, c_hour, c_day, c_mon, c_year;
  logic [7:0] h12;

  assign time_wr = wr_en_i && (wr_addr_i <= A_YEAR);
  assign adv     = adv_i && !time_wr;
  assign h12     = {3'b000, hour_o[4:0]};

  always_comb begin
    sec_n  = sec_o;  min_n  = min_o;  hour_n = hour_o;
    day_n  = day_o;  date_n = date_o; mon_n  = mon_o; year_n = year_o;
    c_hour = 1'b0;   c_day  = 1'b0;   c_mon  = 1'b0;  c_year = 1'b0;

    c_min = (sec_o == 8'h59);
    sec_n = c_min ? 8'h00 : bcd_inc(sec_o);

    if (c_min) begin
      c_hour = (min_o == 8'h59);
      min_n  = c_hour ? 8'h00 : bcd_inc(min_o);
    end

    if (c_hour) begin
      if (hour_o[6]) begin
        if (h12 == 8'h11) begin
          hour_n = {2'b01, ~hour_o[5], 5'h12};
          c_day  = hour_o[5];
        end else if (h12 == 8'h12) begin
          hour_n = {2'b01, hour_o[5], 5'h01};
        end else begin
          hour_n = {2'b01, hour_o[5], bcd_inc(h12)[4:0]};
        end
      end else if (hour_o[5:0] == 6'h23) begin
        hour_n = 8'h00;
        c_day  = 1'b1;
      end else begin
        hour_n = bcd_inc({2'b00, hour_o[5:0]});
      end
    end

    if (c_day) begin
      day_n = (day_o == 8'h07) ? 8'h01 : day_o + 8'h01;
      c_mon = (date_o == month_last(mon_o, year_o));
      date_n = c_mon ? 8'h01 : bcd_inc(date_o);
    end

    if (c_mon) begin
      c_year = (mon_o == 8'h12);
      mon_n  = c_year ? 8'h01 : bcd_inc(mon_o);
    end

    if (c_year) year_n = (year_o == 8'h99) ? 8'h00 : bcd_inc(year_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_o <= 8'h00; min_o <= 8'h00; hour_o <= 8'h00; day_o <= 8'h01;
      date_o <= 8'h01; mon_o <= 8'h01; year_o <= 8'h00; adv_done_o <= 1'b0;
    end else begin
      adv_done_o <= adv;
      if (time_wr) begin
        case (wr_addr_i)
          A_SEC:   sec_o  <= wr_data_i & 8'h7F;
          A_MIN:   min_o  <= wr_data_i & 8'h7F;
          A_HOUR:  hour_o <= wr_data_i & 8'h7F;
          A_DAY:   day_o  <= wr_data_i & 8'h07;
          A_DATE:  date_o <= wr_data_i & 8'h3F;
          A_MON:   mon_o  <= wr_data_i & 8'h1F;
          default: year_o <= wr_data_i;
        endcase
      end else if (adv) begin
        sec_o <= sec_n; min_o <= min_n; hour_o <= hour_n; day_o <= day_n;
        date_o <= date_n; mon_o <= mon_n; year_o <= year_n;
      end
    end
  end

  // R1: seconds 59 rolls to 00 on an advance
  a_r1_sec_roll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !time_wr && sec_o == 8'h59) |=> (sec_o == 8'h00));

  // R2: day of week leaves 7 only towards 1
  a_r2_day_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!time_wr && day_o == 8'h07) |=> (day_o == 8'h07 || day_o == 8'h01));

  // R6: nothing moves without an advance or a write
  a_r6_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !time_wr) |=> ($stable(sec_o) && $stable(date_o) && $stable(year_o)));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [7:0]        sec_i,
  input  logic [7:0]        min_i,
  input  logic [7:0]        hour_i,
  input  logic [7:0]        day_i,
  output logic [7:0]        a_sec_o,
  output logic [7:0]        a_min_o,
  output logic [7:0]        a_hour_o,
  output logic [7:0]        a_day_o,
  output logic              match_o
);
  logic [3:0] fld_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_sec_o <= 8'h00; a_min_o <= 8'h00; a_hour_o <= 8'h00; a_day_o <= 8'h00;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_ASEC:  a_sec_o  <= wr_data_i;
        A_AMIN:  a_min_o  <= wr_data_i;
        A_AHOUR: a_hour_o <= wr_data_i;
        A_ADAY:  a_day_o  <= wr_data_i & 8'h87;
        default: ;
      endcase
    end
  end

  // bit 7 of each alarm register masks its field
  assign fld_hit[0] = a_sec_o[7]  || (a_sec_o[6:0]  == sec_i[6:0]);
  assign fld_hit[1] = a_min_o[7]  || (a_min_o[6:0]  == min_i[6:0]);
  assign fld_hit[2] = a_hour_o[7] || (a_hour_o[6:0] == hour_i[6:0]);
  assign fld_hit[3] = a_day_o[7]  || (a_day_o[2:0]  == day_i[2:0]);
  assign match_o    = &fld_hit;

  // R9: with every mask set the alarm matches at any time
  a_r9_all_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_sec_o[7] && a_min_o[7] && a_hour_o[7] && a_day_o[7]) |-> match_o);
endmodule

// File: rtl/rtc_cal_core.sv
module rtc_cal_core
  import rtc_pkg::*;
#(
  parameter int unsigned DIV_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick32k_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              irq_o
);
  logic [7:0] ctrl_q;
  logic       irqf_q;
  logic       wr_ok, sec_wr, sec_pulse, adv_done, al_match, stat_rd;
  logic [7:0] sec, min, hour, day, date, mon, year;
  logic [7:0] a_sec, a_min, a_hour, a_day;

  assign wr_ok   = reg_we_i && !ctrl_q[CTRL_WP];
  assign sec_wr  = wr_ok && (reg_addr_i == A_SEC);
  assign stat_rd = reg_re_i && (reg_addr_i == A_STAT);

  rtc_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk_i, .rst_ni,
    .tick_i (tick32k_i),
    .run_i  (!ctrl_q[CTRL_HALT]),
    .clr_i  (sec_wr),
    .pulse_o(sec_pulse)
  );

  rtc_timekeeper u_tk (
    .clk_i, .rst_ni,
    .adv_i     (sec_pulse),
    .wr_en_i   (wr_ok),
    .wr_addr_i (reg_addr_i),
    .wr_data_i (reg_wdata_i),
    .sec_o     (sec),
    .min_o     (min),
    .hour_o    (hour),
    .day_o     (day),
    .date_o    (date),
    .mon_o     (mon),
    .year_o    (year),
    .adv_done_o(adv_done)
  );

  rtc_alarm u_alarm (
    .clk_i, .rst_ni,
    .wr_en_i  (wr_ok),
    .wr_addr_i(reg_addr_i),
    .wr_data_i(reg_wdata_i),
    .sec_i    (sec),
    .min_i    (min),
    .hour_i   (hour),
    .day_i    (day),
    .a_sec_o  (a_sec),
    .a_min_o  (a_min),
    .a_hour_o (a_hour),
    .a_day_o  (a_day),
    .match_o  (al_match)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= 8'h00;
    end else if (reg_we_i && reg_addr_i == A_CTRL) begin
      if (ctrl_q[CTRL_WP]) ctrl_q[CTRL_WP] <= reg_wdata_i[CTRL_WP];
      else                 ctrl_q <= reg_wdata_i & CTRL_MASK;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    irqf_q <= 1'b0;
    else if (adv_done && al_match)  irqf_q <= 1'b1;
    else if (stat_rd)               irqf_q <= 1'b0;
  end

  assign irq_o = irqf_q && ctrl_q[CTRL_AIE];

  always_comb begin
    case (reg_addr_i)
      A_SEC:   reg_rdata_o = sec;
      A_MIN:   reg_rdata_o = min;
      A_HOUR:  reg_rdata_o = hour;
      A_DAY:   reg_rdata_o = day;
      A_DATE:  reg_rdata_o = date;
      A_MON:   reg_rdata_o = mon;
      A_YEAR:  reg_rdata_o = year;
      A_ASEC:  reg_rdata_o = a_sec;
      A_AMIN:  reg_rdata_o = a_min;
      A_AHOUR: reg_rdata_o = a_hour;
      A_ADAY:  reg_rdata_o = a_day;
      A_CTRL:  reg_rdata_o = ctrl_q;
      A_STAT:  reg_rdata_o = {7'd0, irqf_q};
      default: reg_rdata_o = 8'h00;
    endcase
  end

  // R10: a matching advance sets the flag on the next edge
  a_r10_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_done && al_match) |=> irqf_q);

  // R10: a status read without a new match clears the flag
  a_r10_flag_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !(adv_done && al_match)) |=> !irqf_q);

  // R7: protected seconds write leaves seconds alone
  a_r7_wp_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[CTRL_WP] && reg_we_i && reg_addr_i == A_SEC && !sec_pulse) |=> $stable(sec));

  // R6: halted clock with no writes keeps seconds
  a_r6_halted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[CTRL_HALT] && !reg_we_i) |=> $stable(sec));

  // R11: interrupt output requires the flag
  a_r11_irq_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irqf_q);
endmodule

// File: tb/rtc_cal_core_bench.sv
module rtc_cal_core_bench;
  localparam int unsigned DIV_W = 4;
  localparam int unsigned SEC_TICKS = 1 << DIV_W;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick32k_i = 1'b0;
  logic       reg_we_i = 1'b0;
  logic       reg_re_i = 1'b0;
  logic [3:0] reg_addr_i = 4'h0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic       irq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  rtc_cal_core #(.DIV_W(DIV_W)) u_rtc_cal_core (.*);

  always #4 clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic stat_rd(output logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = 4'hC; reg_re_i = 1'b1;
    #1 d = reg_rdata_o;
    @(negedge clk_i);
    reg_re_i = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] hr, mi, se, dy, dt, mo, yr);
    wr(4'h6, yr); wr(4'h5, mo); wr(4'h4, dt); wr(4'h3, dy);
    wr(4'h2, hr); wr(4'h1, mi); wr(4'h0, se);
  endtask

  task automatic step_second();
    @(negedge clk_i);
    tick32k_i = 1'b1;
    repeat (SEC_TICKS) @(negedge clk_i);
    tick32k_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic t_reset();
    rd_chk("R12 sec", 4'h0, 8'h00); rd_chk("R12 hour", 4'h2, 8'h00);
    rd_chk("R12 day", 4'h3, 8'h01); rd_chk("R12 date", 4'h4, 8'h01);
    rd_chk("R12 mon", 4'h5, 8'h01); rd_chk("R12 year", 4'h6, 8'h00);
    rd_chk("R12 ctrl", 4'hB, 8'h00); rd_chk("R12 stat", 4'hC, 8'h00);
    rd_chk("R12 aday", 4'hA, 8'h00);
    chk("R12 irq", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_full_roll();
    set_time(8'h23, 8'h59, 8'h59, 8'h07, 8'h31, 8'h12, 8'h99);
    step_second();
    rd_chk("R1 sec", 4'h0, 8'h00); rd_chk("R1 min", 4'h1, 8'h00);
    rd_chk("R2 hour", 4'h2, 8'h00); rd_chk("R2 day", 4'h3, 8'h01);
    rd_chk("R4 date", 4'h4, 8'h01); rd_chk("R4 mon", 4'h5, 8'h01);
    rd_chk("R4 year", 4'h6, 8'h00);
    set_time(8'h09, 8'h14, 8'h30, 8'h02, 8'h10, 8'h05, 8'h40);
    step_second();
    rd_chk("R1 sec inc", 4'h0, 8'h31); rd_chk("R1 min hold", 4'h1, 8'h14);
  endtask

  task automatic t_months();
    set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h24);
    step_second();
    rd_chk("R4 leap feb29", 4'h4, 8'h29);
    set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h29, 8'h02, 8'h24);
    step_second();
    rd_chk("R4 leap mar date", 4'h4, 8'h01); rd_chk("R4 leap mar", 4'h5, 8'h03);
    set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h23);
    step_second();
    rd_chk("R4 common feb", 4'h5, 8'h03);
    set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h00);
    step_second();
    rd_chk("R4 year00 leap", 4'h4, 8'h29);
    set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h30, 8'h04, 8'h10);
    step_second();
    rd_chk("R4 apr30", 4'h5, 8'h05);
    set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h30, 8'h01, 8'h10);
    step_second();
    rd_chk("R4 jan31", 4'h4, 8'h31);
  endtask

  task automatic t_12h();
    set_time(8'h51, 8'h59, 8'h59, 8'h03, 8'h10, 8'h01, 8'h10);
    step_second();
    rd_chk("R3 11am to 12pm", 4'h2, 8'h72); rd_chk("R3 no carry", 4'h3, 8'h03);
    set_time(8'h72, 8'h59, 8'h59, 8'h03, 8'h10, 8'h01, 8'h10);
    step_second();
    rd_chk("R3 12pm to 1pm", 4'h2, 8'h61);
    set_time(8'h52, 8'h59, 8'h59, 8'h03, 8'h10, 8'h01, 8'h10);
    step_second();
    rd_chk("R3 12am to 1am", 4'h2, 8'h41);
    set_time(8'h71, 8'h59, 8'h59, 8'h03, 8'h10, 8'h01, 8'h10);
    step_second();
    rd_chk("R3 11pm to 12am", 4'h2, 8'h52); rd_chk("R3 day carry", 4'h3, 8'h04);
    rd_chk("R3 date carry", 4'h4, 8'h11);
  endtask

  task automatic t_divider();
    set_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h10);
    @(negedge clk_i);
    tick32k_i = 1'b1;
    repeat (SEC_TICKS - 1) @(negedge clk_i);
    tick32k_i = 1'b0;
    rd_chk("R5 one short", 4'h0, 8'h00);
    wr(4'h0, 8'h00);
    @(negedge clk_i);
    tick32k_i = 1'b1;
    repeat (SEC_TICKS - 1) @(negedge clk_i);
    tick32k_i = 1'b0;
    rd_chk("R5 restart by write", 4'h0, 8'h00);
    @(negedge clk_i);
    tick32k_i = 1'b1;
    @(negedge clk_i);
    tick32k_i = 1'b0;
    rd_chk("R5 full count", 4'h0, 8'h01);
  endtask

  task automatic t_halt();
    set_time(8'h10, 8'h00, 8'h20, 8'h01, 8'h01, 8'h01, 8'h10);
    wr(4'hB, 8'h80);
    step_second(); step_second();
    rd_chk("R6 halted", 4'h0, 8'h20);
    wr(4'hB, 8'h00);
    wr(4'h0, 8'h20);
    step_second();
    rd_chk("R6 resumed", 4'h0, 8'h21);
  endtask

  task automatic t_wp();
    wr(4'h0, 8'h15);
    wr(4'hB, 8'h40);
    wr(4'h0, 8'h33); wr(4'h7, 8'h12);
    rd_chk("R7 sec blocked", 4'h0, 8'h15);
    rd_chk("R7 alarm blocked", 4'h7, 8'h00);
    wr(4'hB, 8'h81);
    rd_chk("R7 only wp cleared", 4'hB, 8'h00);
    wr(4'h0, 8'h33);
    rd_chk("R7 write after clear", 4'h0, 8'h33);
  endtask

  task automatic t_masks();
    wr(4'h3, 8'hFF); rd_chk("R8 day bits", 4'h3, 8'h07);
    wr(4'h4, 8'hFF); rd_chk("R8 date bits", 4'h4, 8'h3F);
    wr(4'h5, 8'hFF); rd_chk("R8 month bits", 4'h5, 8'h1F);
    wr(4'h0, 8'hFF); rd_chk("R8 sec bits", 4'h0, 8'h7F);
    wr(4'hA, 8'hFF); rd_chk("R8 aday bits", 4'hA, 8'h87);
    wr(4'hB, 8'h3E); rd_chk("R8 ctrl bits", 4'hB, 8'h30);
    wr(4'hB, 8'h00);
    wr(4'hE, 8'hFF); rd_chk("R8 unmapped", 4'hE, 8'h00);
  endtask

  task automatic set_alarm(input logic [7:0] s, m, h, d);
    wr(4'h7, s); wr(4'h8, m); wr(4'h9, h); wr(4'hA, d);
  endtask

  task automatic t_alarm();
    logic [7:0] st;
    stat_rd(st);
    wr(4'hB, 8'h01);
    set_alarm(8'h80, 8'h80, 8'h80, 8'h80);
    set_time(8'h08, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h10);
    chk("R10 clear before", {7'd0, irq_o}, 8'h00);
    step_second();
    chk("R9 every second irq", {7'd0, irq_o}, 8'h01);
    stat_rd(st);
    chk("R10 status read", st, 8'h01);
    chk("R10 cleared irq", {7'd0, irq_o}, 8'h00);
    rd_chk("R10 cleared stat", 4'hC, 8'h00);

    set_alarm(8'h05, 8'h80, 8'h80, 8'h80);
    wr(4'h0, 8'h04);
    step_second();
    chk("R9 sec match", {7'd0, irq_o}, 8'h01);
    stat_rd(st);
    step_second();
    chk("R9 sec mismatch", {7'd0, irq_o}, 8'h00);

    set_alarm(8'h00, 8'h30, 8'h80, 8'h80);
    wr(4'h1, 8'h29); wr(4'h0, 8'h59);
    step_second();
    chk("R9 min sec match", {7'd0, irq_o}, 8'h01);
    stat_rd(st);
    wr(4'h1, 8'h28); wr(4'h0, 8'h59);
    step_second();
    chk("R9 min mismatch", {7'd0, irq_o}, 8'h00);

    set_alarm(8'h00, 8'h00, 8'h00, 8'h02);
    set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h01, 8'h01, 8'h10);
    step_second();
    chk("R9 weekly match", {7'd0, irq_o}, 8'h01);
    stat_rd(st);
    set_time(8'h23, 8'h59, 8'h59, 8'h02, 8'h01, 8'h01, 8'h10);
    step_second();
    chk("R9 weekly wrong day", {7'd0, irq_o}, 8'h00);

    wr(4'hB, 8'h00);
    set_alarm(8'h80, 8'h80, 8'h80, 8'h80);
    wr(4'h0, 8'h00);
    step_second();
    chk("R11 masked irq", {7'd0, irq_o}, 8'h00);
    rd_chk("R11 flag still set", 4'hC, 8'h01);
    wr(4'hB, 8'h01);
    chk("R11 enable shows flag", {7'd0, irq_o}, 8'h01);
    stat_rd(st);
    wr(4'hB, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_full_roll();
    t_months();
    t_12h();
    t_divider();
    t_halt();
    t_wp();
    t_masks();
    t_alarm();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule